// File: doc/BRIEF.md
# Time-Division Duplex Link Controller

This controller lets two radio units share one half-duplex channel so that speech can flow both ways at once. Each unit alternates between sending one packet and listening for one packet. One unit is strapped as master and paces the exchange. The other is the slave and only answers packets it has received. The controller drives start/done handshakes towards a packet framer and a packet deframer. It takes a buffer-full flag from the sample assembler and a sync-detected strobe from the receiver. It raises a request to refill the receive buffer with silence whenever a packet is lost.

After reset the two units run a two-phase preamble exchange. The slave sends its preamble first while the master listens. Then the master sends while the slave listens. The master gives up listening after a programmable number of cycles, so the two units may power up in either order. In normal operation a lost packet makes the master refill its buffer with silence and go back to sending. A lost packet makes the slave refill its buffer and keep listening. The refill value is the mid-scale code, so a stale packet is never replayed as a looping sound.

Top module: `tdd_link_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after its release, `tx_start`, `tx_preamble`, `tx_busy`, `rx_listen`, `fill_req`, `tmo_evt` and `link_up` are all 0.
- R2: The role is taken from `is_master_strap` only while `rst` is high and is shown on `role_master`. Changing the strap outside reset changes no output.
- R3: Slave start-up: after the boot cycle it raises `tx_start` with `tx_preamble`=1. On `tx_done` it listens (`rx_listen`=1) with no time limit. On `sync_det` it enters normal operation (`link_up`=1), still listening.
- R4: Master start-up: after the boot cycle it listens with the timeout running. On `sync_det`, or on expiry, it raises `tx_start` with `tx_preamble`=1. On `tx_done` it enters normal operation in the idle state (`link_up`=1, `tx_busy`=0, `rx_listen`=0).
- R5: A master that is idle in normal operation starts a data packet (`tx_start` with `tx_preamble`=0) the cycle after it sees `buf_full`. On `tx_done` it listens for sync.
- R6: A timed sync wait without `sync_det` expires after exactly max(`tmo_limit`,1) cycles in that wait. A `sync_det` in the last cycle wins over expiry. `tmo_limit` must be held steady during a wait.
- R7: When a master's normal sync wait expires, `fill_req` and `tmo_evt` pulse for one cycle and the master returns to idle.
- R8: When a slave's normal sync wait expires, `fill_req` and `tmo_evt` pulse for one cycle. The slave stays listening and starts a fresh full timeout window.
- R9: After `sync_det` in normal operation the unit keeps listening until `rx_done`. A master then goes idle. A slave then starts a data packet (`tx_start`, `tx_preamble`=0).
- R10: `fill_code` equals the mid-scale silence code, 128 for 8-bit samples.
- R11: `tx_start` is a single-cycle pulse in the first cycle of each transmission. `tx_busy` stays high from that cycle until the cycle after `tx_done`.
- R12: Inputs are ignored outside the state that consumes them. These are `buf_full` except in master idle, `tx_done` except while transmitting, `sync_det` except while waiting for sync, and `rx_done` except while receiving data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master_strap | input | 1 | 1 selects master role, sampled in reset |
| tmo_limit | input | TMO_W | Sync-wait timeout in cycles (0 acts as 1) |
| buf_full | input | 1 | Transmit buffer holds a full packet |
| tx_done | input | 1 | Framer finished the current transmission |
| sync_det | input | 1 | Receiver found the sync byte |
| rx_done | input | 1 | Deframer finished a correct packet |
| tx_start | output | 1 | One-cycle start request to the framer |
| tx_preamble | output | 1 | Current transmission is a start-up preamble only |
| tx_busy | output | 1 | Unit is transmitting |
| rx_listen | output | 1 | Unit is receiving or waiting for sync |
| fill_req | output | 1 | Pulse: reset receive buffer to silence |
| fill_code | output | SAMPLE_W | Silence value to fill with |
| tmo_evt | output | 1 | Pulse: a packet was lost |
| link_up | output | 1 | Start-up exchange completed |
| role_master | output | 1 | Latched role |

## Verification
Most faults in this controller show up as a state that is correct in kind but reached one cycle early or late. Examples are a timeout window off by one, or a start pulse that repeats. The bench runs a behavioural model beside the design and compares every output on every cycle, so such a fault shows within the cycle in which it happens. A wrong role decision shows at once in `tx_start` or `rx_listen` after the boot cycle. A wrong branch after a lost packet shows within one cycle in whether `rx_listen` stays high.

// File: rtl/tdd_pkg.sv
package tdd_pkg;

    typedef enum logic [2:0] {
        ST_BOOT    = 3'd0,
        ST_PRE_TX  = 3'd1,
        ST_PRE_RX  = 3'd2,
        ST_IDLE    = 3'd3,
        ST_TX      = 3'd4,
        ST_RX_SYNC = 3'd5,
        ST_RX_DATA = 3'd6
    } tdd_state_t;

    function automatic logic st_is_tx(tdd_state_t s);
        return (s == ST_PRE_TX) || (s == ST_TX);
    endfunction

    function automatic logic st_is_rx(tdd_state_t s);
        return (s == ST_PRE_RX) || (s == ST_RX_SYNC) || (s == ST_RX_DATA);
    endfunction

    function automatic logic st_is_normal(tdd_state_t s);
        return (s == ST_IDLE) || (s == ST_TX) || (s == ST_RX_SYNC) || (s == ST_RX_DATA);
    endfunction

endpackage

// File: rtl/tdd_timer.sv
module tdd_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    assign expire  = run && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_inc[CW-1:0];
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt == '0 || cnt < limit)); // R6

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(run)) |-> (cnt == '0)); // R6

endmodule

// File: rtl/tdd_fsm.sv
module tdd_fsm
    import tdd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strap,
    input  logic       buf_full,
    input  logic       tx_done,
    input  logic       sync_det,
    input  logic       rx_done,
    input  logic       expire,
    output logic       run,
    output tdd_state_t state,
    output logic       first,
    output logic       lost,
    output logic       role
);
    tdd_state_t state_q, state_d;
    logic       first_q, lost_q, lost_d, role_q;

    assign run = (state_q == ST_RX_SYNC) || (state_q == ST_PRE_RX && role_q);

    always_comb begin
        state_d = state_q;
        lost_d  = 1'b0;
        unique case (state_q)
            ST_BOOT:    state_d = role_q ? ST_PRE_RX : ST_PRE_TX;
            ST_PRE_TX:  if (tx_done) state_d = role_q ? ST_IDLE : ST_PRE_RX;
            ST_PRE_RX:  begin
                if (sync_det)    state_d = role_q ? ST_PRE_TX : ST_RX_SYNC;
                else if (expire) state_d = ST_PRE_TX;
            end
            ST_IDLE:    if (buf_full) state_d = ST_TX;
            ST_TX:      if (tx_done) state_d = ST_RX_SYNC;
            ST_RX_SYNC: begin
                if (sync_det) begin
                    state_d = ST_RX_DATA;
                end else if (expire) begin
                    lost_d  = 1'b1;
                    state_d = role_q ? ST_IDLE : ST_RX_SYNC;
                end
            end
            ST_RX_DATA: if (rx_done) state_d = role_q ? ST_IDLE : ST_TX;
            default:    state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            first_q <= 1'b0;
            lost_q  <= 1'b0;
            role_q  <= strap;
        end else begin
            state_q <= state_d;
            first_q <= (state_d != state_q);
            lost_q  <= lost_d;
        end
    end

    assign state = state_q;
    assign first = first_q;
    assign lost  = lost_q;
    assign role  = role_q;

    AST_ROLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        $stable(role_q)); // R2

    AST_TX_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        (first_q && st_is_tx(state_q)) |=> !(first_q && st_is_tx(state_q))); // R11

    AST_MASTER_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (role_q && lost_q) |-> (state_q == ST_IDLE)); // R7

    AST_SLAVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!role_q && lost_q) |-> (state_q == ST_RX_SYNC)); // R8

    AST_REPLY_AFTER_RX: assert property (@(posedge clk) disable iff (rst)
        (!role_q && state_q == ST_TX && first_q) |-> ($past(state_q) == ST_RX_DATA)); // R9

endmodule

// File: rtl/tdd_link_ctrl.sv
module tdd_link_ctrl
    import tdd_pkg::*;
#(
    parameter int TMO_W    = 16,
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                is_master_strap,
    input  logic [TMO_W-1:0]    tmo_limit,
    input  logic                buf_full,
    input  logic                tx_done,
    input  logic                sync_det,
    input  logic                rx_done,
    output logic                tx_start,
    output logic                tx_preamble,
    output logic                tx_busy,
    output logic                rx_listen,
    output logic                fill_req,
    output logic [SAMPLE_W-1:0] fill_code,
    output logic                tmo_evt,
    output logic                link_up,
    output logic                role_master
);
    localparam logic [SAMPLE_W-1:0] MID_CODE = SAMPLE_W'(1) << (SAMPLE_W - 1);

    tdd_state_t st;
    logic       run, expire, first, lost, role;

    tdd_timer #(.CW(TMO_W)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .limit  (tmo_limit),
        .expire (expire)
    );

    tdd_fsm i_fsm (
        .clk      (clk),
        .rst      (rst),
        .strap    (is_master_strap),
        .buf_full (buf_full),
        .tx_done  (tx_done),
        .sync_det (sync_det),
        .rx_done  (rx_done),
        .expire   (expire),
        .run      (run),
        .state    (st),
        .first    (first),
        .lost     (lost),
        .role     (role)
    );

    assign tx_busy     = st_is_tx(st);
    assign tx_start    = first && st_is_tx(st);
    assign tx_preamble = (st == ST_PRE_TX);
    assign rx_listen   = st_is_rx(st);
    assign link_up     = st_is_normal(st);
    assign fill_req    = lost;
    assign tmo_evt     = lost;
    assign fill_code   = MID_CODE;
    assign role_master = role;

    AST_NO_TX_DURING_LISTEN: assert property (@(posedge clk) disable iff (rst)
        rx_listen |-> !tx_start); // R12

    AST_FILL_ONLY_LINKED: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> (link_up && !tx_busy)); // R7

endmodule

// File: tb/test_tdd_link_ctrl.sv
module test_tdd_link_ctrl;
    localparam int TMO_W = 16;
    localparam int SAMPLE_W = 8;

    logic clk = 1'b0;
    logic rst, strap, buf_full, tx_done, sync_det, rx_done;
    logic [TMO_W-1:0] tmo_limit;
    logic tx_start, tx_preamble, tx_busy, rx_listen, fill_req, tmo_evt, link_up, role_master;
    logic [SAMPLE_W-1:0] fill_code;

    always #4 clk = ~clk;

    tdd_link_ctrl #(.TMO_W(TMO_W), .SAMPLE_W(SAMPLE_W)) i_tdd_link_ctrl (
        .clk(clk), .rst(rst), .is_master_strap(strap), .tmo_limit(tmo_limit),
        .buf_full(buf_full), .tx_done(tx_done), .sync_det(sync_det), .rx_done(rx_done),
        .tx_start(tx_start), .tx_preamble(tx_preamble), .tx_busy(tx_busy),
        .rx_listen(rx_listen), .fill_req(fill_req), .fill_code(fill_code),
        .tmo_evt(tmo_evt), .link_up(link_up), .role_master(role_master)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    string cur_tag = "R1";

    // behavioural model: phases 0 boot,1 preamble send,2 preamble listen,3 idle,4 send,5 sync wait,6 data receive
    int  m_st = 0, m_wait = 0;
    bit  m_role = 0, m_first = 0, m_lost = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_role = strap; m_st = 0; m_first = 0; m_wait = 0; m_lost = 0;
        end else begin
            int nx;
            bit waiting, exp_now, lost_now;
            waiting  = (m_st == 5) || (m_st == 2 && m_role);
            exp_now  = waiting && (m_wait + 1 >= int'(tmo_limit));
            nx       = m_st;
            lost_now = 0;
            case (m_st)
                0: nx = m_role ? 2 : 1;
                1: if (tx_done) nx = m_role ? 3 : 2;
                2: if (sync_det) nx = m_role ? 1 : 5; else if (exp_now) nx = 1;
                3: if (buf_full) nx = 4;
                4: if (tx_done) nx = 5;
                5: if (sync_det) nx = 6;
                   else if (exp_now) begin lost_now = 1; nx = m_role ? 3 : 5; end
                6: if (rx_done) nx = m_role ? 3 : 4;
                default: nx = 0;
            endcase
            m_wait  = (waiting && !exp_now) ? m_wait + 1 : 0;
            m_first = (nx != m_st);
            m_lost  = lost_now;
            m_st    = nx;
        end
    end

    task automatic cmp1(string name, logic act, bit exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b (t=%0t)", cur_tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            cmp1("tx_start",    tx_start,    m_first && (m_st == 1 || m_st == 4));
            cmp1("tx_preamble", tx_preamble, m_st == 1);
            cmp1("tx_busy",     tx_busy,     m_st == 1 || m_st == 4);
            cmp1("rx_listen",   rx_listen,   m_st == 2 || m_st == 5 || m_st == 6);
            cmp1("fill_req",    fill_req,    m_lost);
            cmp1("tmo_evt",     tmo_evt,     m_lost);
            cmp1("link_up",     link_up,     m_st >= 3);
            cmp1("role_master", role_master, m_role);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx_done();  tx_done = 1;  tick(1); tx_done = 0;  endtask
    task automatic pulse_sync();     sync_det = 1; tick(1); sync_det = 0; endtask
    task automatic pulse_rx_done();  rx_done = 1;  tick(1); rx_done = 0;  endtask
    task automatic pulse_buf_full(); buf_full = 1; tick(1); buf_full = 0; endtask

    task automatic do_reset(bit master, int lim);
        rst = 1; strap = master; tmo_limit = TMO_W'(lim);
        buf_full = 0; tx_done = 0; sync_det = 0; rx_done = 0;
        tick(3);
        rst = 0;
    endtask

    task automatic wait_phase(int ph);
        for (int g = 0; g < 200 && m_st != ph; g++) tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cur_tag = "R1";
        rst = 1; strap = 0; tmo_limit = 16'd6;
        buf_full = 0; tx_done = 0; sync_det = 0; rx_done = 0;
        tick(1); cmp_en = 1; tick(2);
        rst = 0; tick(1);

        checks++;
        if (fill_code !== 8'd128) begin
            errors++;
            $display("FAIL R10 fill_code: actual %0d expected 128", fill_code);
        end

        // slave start-up with strap flipped after reset
        cur_tag = "R2"; strap = 1; tick(3);
        cur_tag = "R3"; pulse_tx_done(); tick(20); pulse_sync(); tick(2);
        // slave normal packet and reply
        cur_tag = "R9"; pulse_sync(); tick(3); pulse_rx_done(); tick(3);
        cur_tag = "R11"; tick(2); pulse_tx_done(); tick(1);
        // slave lost packets
        cur_tag = "R8"; tick(15);
        cur_tag = "R12"; pulse_buf_full(); pulse_tx_done(); pulse_rx_done(); tick(4);
        pulse_sync(); pulse_sync(); pulse_buf_full(); tick(2); pulse_rx_done(); pulse_sync(); tick(3);

        // master start-up via timeout
        cur_tag = "R1"; do_reset(1, 4); tick(1);
        cur_tag = "R4"; tick(6); pulse_tx_done(); tick(2);
        cur_tag = "R5"; tick(2); pulse_buf_full(); tick(3); pulse_tx_done();
        cur_tag = "R7"; tick(8);
        cur_tag = "R6"; pulse_buf_full(); tick(1); pulse_tx_done();
        wait_phase(5);
        for (int g = 0; g < 20 && !(m_st == 5 && m_wait == int'(tmo_limit) - 1); g++) tick(1);
        pulse_sync(); tick(1);
        cur_tag = "R9"; pulse_rx_done(); tick(2);
        cur_tag = "R6"; tmo_limit = 16'd0; pulse_buf_full(); pulse_tx_done(); tick(4);

        // master start-up via sync
        cur_tag = "R4"; do_reset(1, 30); tick(3); pulse_sync(); tick(2); pulse_tx_done(); tick(2);

        // random traffic, both roles
        cur_tag = "R12";
        for (int r = 0; r < 8; r++) begin
            do_reset(r[0], 1 + (r % 5));
            for (int c = 0; c < 1500; c++) begin
                buf_full = ($urandom_range(0, 3) == 0);
                tx_done  = ($urandom_range(0, 5) == 0);
                sync_det = ($urandom_range(0, 6) == 0);
                rx_done  = ($urandom_range(0, 4) == 0);
                strap    = $urandom_range(0, 1);
                tick(1);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule